// File: doc/BRIEF.md
# CPU Address Decoder with Sprite Page Copier

This block sits between an 8-bit CPU bus and the peripherals around it. Every CPU read or write is steered to exactly one target: the work RAM, the video register port, the audio registers, one of two controller ports, the controller strobe latch or the cartridge port. Mirrored regions are folded down to the offset width of their target. A read and a write to the same address may reach different targets. Read data from the selected target is returned to the CPU in the same cycle.

A CPU write to the trigger address starts a page copier. The written byte names a 256-byte source page. The copier takes the bus from the CPU and raises a stall line. It then reads each byte of the page in ascending order and writes it to the sprite-data register of the video port, so it spends two bus cycles per byte. When the last write is done, the stall is released and a one-cycle done pulse is given.

Top module: `cpu_bus_fabric`

## Requirements
- R1: A CPU access in 0x0000–0x1FFF asserts `ram_sel_o`, and the offset is the address modulo 0x800 (`ram_addr_o` = addr[10:0]).
- R2: A CPU access in 0x2000–0x3FFF asserts `vid_sel_o`, and the register index is the address modulo 8 (`vid_reg_o` = addr[2:0]).
- R3: Reads and writes at 0x4000–0x4013 and at 0x4015 assert `snd_sel_o`, and the offset is `snd_addr_o` = addr[4:0].
- R4: A read of 0x4017 asserts `pad1_rd_o` and returns `pad1_data_i`. A write to 0x4017 goes to the audio target.
- R5: A read of 0x4016 asserts `pad0_rd_o` and returns `pad0_data_i`. A write to 0x4016 loads data bit 0 into `pad_strobe_o`, which keeps that value until the next such write.
- R6: A CPU access in 0x4018–0xFFFF asserts `cart_sel_o`, and `cart_addr_o` carries the full address.
- R7: A read that maps to no target (0x4014) asserts no select and returns 0x00.
- R8: A write to 0x4014 starts a copy from page P = the written byte. `cpu_stall_o` goes high the next cycle and stays high for exactly 512 cycles. During that time reads of P*0x100+i and writes of the read byte to video register 4 alternate, with i running from 0 to 255 in order.
- R9: `dma_done_o` is high for exactly one cycle, which is the first cycle in which `cpu_stall_o` is low again after a copy.
- R10: While `cpu_stall_o` is high, CPU reads and writes have no effect on any target.
- R11: After reset, `cpu_stall_o`, `dma_done_o` and `pad_strobe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rdata_o | output | 8 | Read data to CPU |
| cpu_stall_o | output | 1 | CPU must hold while high |
| dma_done_o | output | 1 | One-cycle pulse at end of copy |
| bus_wdata_o | output | 8 | Write data to all targets |
| ram_sel_o | output | 1 | Work RAM select |
| ram_we_o | output | 1 | Work RAM write enable |
| ram_addr_o | output | 11 | Work RAM offset |
| ram_rdata_i | input | 8 | Work RAM read data |
| vid_sel_o | output | 1 | Video port select |
| vid_we_o | output | 1 | Video port write enable |
| vid_reg_o | output | 3 | Video register index |
| vid_rdata_i | input | 8 | Video port read data |
| snd_sel_o | output | 1 | Audio select |
| snd_we_o | output | 1 | Audio write enable |
| snd_addr_o | output | 5 | Audio register offset |
| snd_rdata_i | input | 8 | Audio read data |
| pad0_rd_o | output | 1 | First controller read |
| pad0_data_i | input | 8 | First controller state |
| pad1_rd_o | output | 1 | Second controller read |
| pad1_data_i | input | 8 | Second controller state |
| pad_strobe_o | output | 1 | Controller strobe level |
| cart_sel_o | output | 1 | Cartridge select |
| cart_we_o | output | 1 | Cartridge write enable |
| cart_addr_o | output | 16 | Cartridge address |
| cart_rdata_i | input | 8 | Cartridge read data |

## Verification
A CPU access and a copier access can fall in the same cycle, because the CPU may keep driving its strobes while the stall is high. The bench drives a CPU write into a RAM location partway through a copy. It then checks that the copy lands in the sprite model intact and in order, that the stall lasts exactly 512 cycles, and that reading the RAM location afterwards returns its earlier value. A second copy sourced from the cartridge region checks that the copier's reads go through the same decode as CPU reads.

// File: rtl/bus_fab_pkg.sv
package bus_fab_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] VID_BASE  = 16'h2000;
  localparam logic [ADDR_W-1:0] IO_BASE   = 16'h4000;
  localparam logic [ADDR_W-1:0] SND_LAST  = 16'h4013;
  localparam logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014;
  localparam logic [ADDR_W-1:0] SND_CTRL  = 16'h4015;
  localparam logic [ADDR_W-1:0] PAD0_ADDR = 16'h4016;
  localparam logic [ADDR_W-1:0] PAD1_ADDR = 16'h4017;

  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_VID,
    TGT_SND,
    TGT_PAD0,
    TGT_PAD1,
    TGT_CART,
    TGT_TRIG,
    TGT_STROBE
  } tgt_e;
endpackage

// File: rtl/bus_addr_decode.sv
module bus_addr_decode
  import bus_fab_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output tgt_e              tgt_o
);
  always_comb begin
    tgt_o = TGT_NONE;
    if (rd_i || wr_i) begin
      if (addr_i < VID_BASE)       tgt_o = TGT_RAM;
      else if (addr_i < IO_BASE)   tgt_o = TGT_VID;
      else if (addr_i <= SND_LAST) tgt_o = TGT_SND;
      else begin
        unique case (addr_i)
          TRIG_ADDR: tgt_o = wr_i ? TGT_TRIG   : TGT_NONE;
          SND_CTRL:  tgt_o = TGT_SND;
          PAD0_ADDR: tgt_o = wr_i ? TGT_STROBE : TGT_PAD0;
          PAD1_ADDR: tgt_o = wr_i ? TGT_SND    : TGT_PAD1;
          default:   tgt_o = TGT_CART;
        endcase
      end
    end
  end
endmodule

// File: rtl/sprite_page_dma.sv
module sprite_page_dma
  import bus_fab_pkg::*;
#(
  parameter int XFER_LEN = 256,
  parameter int SPR_REG  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] page_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int IDX_W = $clog2(XFER_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(XFER_LEN - 1);
  localparam logic [ADDR_W-1:0] SPR_ADDR = VID_BASE + ADDR_W'(SPR_REG);

  logic              wr_phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] page_q, byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      wr_phase_q <= 1'b0;
      idx_q      <= '0;
      page_q     <= '0;
      byte_q     <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o     <= 1'b1;
          page_q     <= page_i;
          idx_q      <= '0;
          wr_phase_q <= 1'b0;
        end
      end else if (!wr_phase_q) begin
        byte_q     <= rdata_i;
        wr_phase_q <= 1'b1;
      end else begin
        wr_phase_q <= 1'b0;
        idx_q      <= idx_q + 1'b1;
        if (idx_q == IDX_LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign addr_o  = wr_phase_q ? SPR_ADDR
                              : ({page_q, {DATA_W{1'b0}}} + ADDR_W'(idx_q));
  assign rd_o    = busy_o && !wr_phase_q;
  assign wr_o    = busy_o && wr_phase_q;
  assign wdata_o = byte_q;

  // R8: every copier read is followed by its write
  a_r8_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o);
  // R9: done only on the cycle after the copier lets go
  a_r9_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/cpu_bus_fabric.sv
module cpu_bus_fabric
  import bus_fab_pkg::*;
#(
  parameter int XFER_LEN = 256,
  parameter int SPR_REG  = 4,
  parameter int RAM_AW   = 11,
  parameter int VID_AW   = 3,
  parameter int SND_AW   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  output logic [7:0]        cpu_rdata_o,
  output logic              cpu_stall_o,
  output logic              dma_done_o,
  output logic [7:0]        bus_wdata_o,
  output logic              ram_sel_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              vid_sel_o,
  output logic              vid_we_o,
  output logic [VID_AW-1:0] vid_reg_o,
  input  logic [7:0]        vid_rdata_i,
  output logic              snd_sel_o,
  output logic              snd_we_o,
  output logic [SND_AW-1:0] snd_addr_o,
  input  logic [7:0]        snd_rdata_i,
  output logic              pad0_rd_o,
  input  logic [7:0]        pad0_data_i,
  output logic              pad1_rd_o,
  input  logic [7:0]        pad1_data_i,
  output logic              pad_strobe_o,
  output logic              cart_sel_o,
  output logic              cart_we_o,
  output logic [15:0]       cart_addr_o,
  input  logic [7:0]        cart_rdata_i
);
  logic [ADDR_W-1:0] dma_addr, bus_addr;
  logic [DATA_W-1:0] dma_wdata, bus_rdata;
  logic              dma_rd, dma_wr, dma_busy, bus_rd, bus_wr;
  tgt_e              tgt;

  // copier owns the bus while busy; CPU strobes are dropped
  assign bus_addr    = dma_busy ? dma_addr  : cpu_addr_i;
  assign bus_rd      = dma_busy ? dma_rd    : cpu_rd_i;
  assign bus_wr      = dma_busy ? dma_wr    : cpu_wr_i;
  assign bus_wdata_o = dma_busy ? dma_wdata : cpu_wdata_i;

  bus_addr_decode u_dec (
    .addr_i (bus_addr),
    .rd_i   (bus_rd),
    .wr_i   (bus_wr),
    .tgt_o  (tgt)
  );

  assign ram_sel_o   = (tgt == TGT_RAM);
  assign ram_we_o    = ram_sel_o && bus_wr;
  assign ram_addr_o  = bus_addr[RAM_AW-1:0];
  assign vid_sel_o   = (tgt == TGT_VID);
  assign vid_we_o    = vid_sel_o && bus_wr;
  assign vid_reg_o   = bus_addr[VID_AW-1:0];
  assign snd_sel_o   = (tgt == TGT_SND);
  assign snd_we_o    = snd_sel_o && bus_wr;
  assign snd_addr_o  = bus_addr[SND_AW-1:0];
  assign pad0_rd_o   = (tgt == TGT_PAD0);
  assign pad1_rd_o   = (tgt == TGT_PAD1);
  assign cart_sel_o  = (tgt == TGT_CART);
  assign cart_we_o   = cart_sel_o && bus_wr;
  assign cart_addr_o = bus_addr;

  always_comb begin
    unique case (tgt)
      TGT_RAM:  bus_rdata = ram_rdata_i;
      TGT_VID:  bus_rdata = vid_rdata_i;
      TGT_SND:  bus_rdata = snd_rdata_i;
      TGT_PAD0: bus_rdata = pad0_data_i;
      TGT_PAD1: bus_rdata = pad1_data_i;
      TGT_CART: bus_rdata = cart_rdata_i;
      default:  bus_rdata = '0;
    endcase
  end

  assign cpu_rdata_o = dma_busy ? '0 : bus_rdata;
  assign cpu_stall_o = dma_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pad_strobe_o <= 1'b0;
    else if (tgt == TGT_STROBE) pad_strobe_o <= bus_wdata_o[0];
  end

  sprite_page_dma #(
    .XFER_LEN (XFER_LEN),
    .SPR_REG  (SPR_REG)
  ) u_dma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tgt == TGT_TRIG),
    .page_i  (cpu_wdata_i),
    .rdata_i (bus_rdata),
    .busy_o  (dma_busy),
    .done_o  (dma_done_o),
    .addr_o  (dma_addr),
    .rd_o    (dma_rd),
    .wr_o    (dma_wr),
    .wdata_o (dma_wdata)
  );

  // R8: trigger write stalls the CPU from the next cycle
  a_r8_stall_on_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_stall_o && cpu_wr_i && cpu_addr_i == TRIG_ADDR) |=> cpu_stall_o);
  // R10: the copier never writes RAM, so no RAM write while stalled
  a_r10_no_ram_write_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |-> !ram_we_o);
  // R7: the trigger address reads as zero
  a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_stall_o && cpu_rd_i && !cpu_wr_i && cpu_addr_i == TRIG_ADDR)
      |-> (cpu_rdata_o == 8'h00 && !ram_sel_o && !vid_sel_o && !snd_sel_o && !cart_sel_o));
  // R5: strobe level only moves after a strobe write
  a_r5_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_wr_i && !cpu_stall_o && cpu_addr_i == PAD0_ADDR) |=> $stable(pad_strobe_o));
endmodule

// File: tb/cpu_bus_fabric_tb_top.sv
module cpu_bus_fabric_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata, bus_wdata;
  logic        stall, done;
  logic        ram_sel, ram_we, vid_sel, vid_we, snd_sel, snd_we;
  logic        pad0_rd, pad1_rd, strobe, cart_sel, cart_we;
  logic [10:0] ram_addr;
  logic [2:0]  vid_reg;
  logic [4:0]  snd_addr;
  logic [15:0] cart_addr;
  logic [7:0]  ram_rdata, vid_rdata, snd_rdata, cart_rdata;

  int n_chk = 0, n_bad = 0;
  logic [7:0] ram_m [2048];
  logic [7:0] oam_m [256];
  int         oam_ptr = 0;
  logic       oam_clr = 1'b0;

  always #10 clk = ~clk;

  cpu_bus_fabric dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr),
    .cpu_rdata_o(cpu_rdata), .cpu_stall_o(stall), .dma_done_o(done), .bus_wdata_o(bus_wdata),
    .ram_sel_o(ram_sel), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_rdata_i(ram_rdata),
    .vid_sel_o(vid_sel), .vid_we_o(vid_we), .vid_reg_o(vid_reg), .vid_rdata_i(vid_rdata),
    .snd_sel_o(snd_sel), .snd_we_o(snd_we), .snd_addr_o(snd_addr), .snd_rdata_i(snd_rdata),
    .pad0_rd_o(pad0_rd), .pad0_data_i(8'h11), .pad1_rd_o(pad1_rd), .pad1_data_i(8'h22),
    .pad_strobe_o(strobe),
    .cart_sel_o(cart_sel), .cart_we_o(cart_we), .cart_addr_o(cart_addr), .cart_rdata_i(cart_rdata)
  );

  // target models
  assign ram_rdata  = ram_m[ram_addr];
  assign vid_rdata  = 8'h50 | {5'd0, vid_reg};
  assign snd_rdata  = 8'hA0 ^ {3'd0, snd_addr};
  assign cart_rdata = cart_addr[7:0] ^ cart_addr[15:8];

  always @(posedge clk) begin
    if (ram_sel && ram_we) ram_m[ram_addr] <= bus_wdata;
    if (oam_clr) oam_ptr <= 0;
    else if (vid_sel && vid_we && vid_reg == 3'd4) begin
      oam_m[oam_ptr[7:0]] <= bus_wdata;
      oam_ptr <= oam_ptr + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int obs_code();
    if (ram_sel)  return 1;
    if (vid_sel)  return 2;
    if (snd_sel)  return 3;
    if (pad0_rd)  return 4;
    if (pad1_rd)  return 5;
    if (cart_sel) return 6;
    return 0;
  endfunction

  task automatic cpu_access(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = !w;
    @(posedge clk);
    #1 cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [3:0]  code;
    logic [7:0]  exp;
  } vec_t;

  // codes: 0 none, 1 ram, 2 vid, 3 snd, 4 pad0, 5 pad1, 6 cart
  localparam vec_t VEC [17] = '{
    '{4'd1, 1'b1, 16'h0005, 8'h3C, 4'd1, 8'h00},  // R1 write
    '{4'd1, 1'b0, 16'h0805, 8'h00, 4'd1, 8'h3C},  // R1 mirror
    '{4'd1, 1'b0, 16'h1805, 8'h00, 4'd1, 8'h3C},  // R1 top mirror
    '{4'd2, 1'b0, 16'h2002, 8'h00, 4'd2, 8'h52},  // R2
    '{4'd2, 1'b0, 16'h3FFC, 8'h00, 4'd2, 8'h54},  // R2 mirror
    '{4'd2, 1'b1, 16'h2806, 8'h77, 4'd2, 8'h00},  // R2 write
    '{4'd3, 1'b0, 16'h4000, 8'h00, 4'd3, 8'hA0},  // R3
    '{4'd3, 1'b0, 16'h4015, 8'h00, 4'd3, 8'hB5},  // R3
    '{4'd3, 1'b0, 16'h4013, 8'h00, 4'd3, 8'hB3},  // R3
    '{4'd4, 1'b0, 16'h4017, 8'h00, 4'd5, 8'h22},  // R4 read
    '{4'd4, 1'b1, 16'h4017, 8'h40, 4'd3, 8'h00},  // R4 write
    '{4'd5, 1'b0, 16'h4016, 8'h00, 4'd4, 8'h11},  // R5 read
    '{4'd5, 1'b1, 16'h4016, 8'h01, 4'd0, 8'h00},  // R5 strobe
    '{4'd7, 1'b0, 16'h4014, 8'h00, 4'd0, 8'h00},  // R7
    '{4'd6, 1'b0, 16'h4018, 8'h00, 4'd6, 8'h58},  // R6
    '{4'd6, 1'b0, 16'hFFFF, 8'h00, 4'd6, 8'h00},  // R6
    '{4'd6, 1'b0, 16'h8123, 8'h00, 4'd6, 8'hA2}   // R6
  };

  task automatic run_copy(input logic [7:0] page, input bit inject, input string tag);
    int busy_cnt;
    int oam_bad;
    @(negedge clk); oam_clr = 1'b1;
    @(negedge clk); oam_clr = 1'b0;
    cpu_access(1'b1, 16'h4014, page);
    busy_cnt = 0;
    @(negedge clk);
    while (stall && busy_cnt < 600) begin
      busy_cnt++;
      if (inject && busy_cnt == 100) begin  // R10: CPU write collides with copy
        cpu_addr = 16'h0010; cpu_wdata = 8'hEE; cpu_wr = 1'b1;
      end else begin
        cpu_wr = 1'b0; cpu_rd = 1'b0;
      end
      @(negedge clk);
    end
    cpu_wr = 1'b0;
    check({tag, " R8 stall length"}, busy_cnt, 512);
    check({tag, " R9 done pulse"}, done, 1);
    @(negedge clk);
    check({tag, " R9 done single"}, done, 0);
    check({tag, " R8 sprite writes"}, oam_ptr, 256);
    oam_bad = 0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      e = (page < 8'h20) ? ram_m[{page[2:0], 8'(i)}] : (8'(i) ^ page);
      if (oam_m[i] !== e) oam_bad++;
    end
    check({tag, " R8 sprite data"}, oam_bad, 0);
  endtask

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 stall", stall, 0);
    check("R11 done", done, 0);
    check("R11 strobe", strobe, 0);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      @(negedge clk);
      cpu_addr = VEC[k].addr; cpu_wdata = VEC[k].data;
      cpu_wr = VEC[k].wr; cpu_rd = !VEC[k].wr;
      #5;
      check($sformatf("R%0d target @%h", VEC[k].req, VEC[k].addr), obs_code(), VEC[k].code);
      if (!VEC[k].wr)
        check($sformatf("R%0d data @%h", VEC[k].req, VEC[k].addr), cpu_rdata, VEC[k].exp);
      @(posedge clk);
      #1 cpu_wr = 1'b0; cpu_rd = 1'b0;
    end

    @(negedge clk);
    check("R5 strobe set", strobe, 1);
    cpu_access(1'b1, 16'h4016, 8'hFE);
    @(negedge clk);
    check("R5 strobe clear", strobe, 0);

    // R1 offset and R6 full address at the ports
    @(negedge clk);
    cpu_addr = 16'h1ABC; cpu_rd = 1'b1; #5;
    check("R1 offset", ram_addr, 11'h2BC);
    cpu_addr = 16'hC0DE; #5;
    check("R6 address", cart_addr, 16'hC0DE);
    cpu_rd = 1'b0;

    // preload page 3 and a sentinel through the CPU path
    for (int i = 0; i < 256; i++) cpu_access(1'b1, 16'h0300 + 16'(i), 8'(i * 7 + 3));
    cpu_access(1'b1, 16'h0010, 8'h42);

    run_copy(8'h03, 1'b1, "ram page");
    @(negedge clk);
    cpu_addr = 16'h0010; cpu_rd = 1'b1; #5;
    check("R10 ram untouched", cpu_rdata, 8'h42);
    cpu_rd = 1'b0;

    run_copy(8'h90, 1'b0, "cart page");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule